// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder, plus its once-per-revolution index mark, into a 16-bit position count. The encoder pins are synchronised inside the block, edges are decoded into up or down steps, and the count follows them. A direction bit reports the sense of the last counted step.

A 3-bit mode field sets the resolution and the reset behaviour. In 2x resolution only phase A edges count. In 4x resolution every edge of either phase counts. The reset behaviour is either a clear on the rising edge of the index input, or a roll to zero once the count passes a programmed maximum. In the index-reset modes the counter wraps through the full 16-bit range, and each wrap sets a sticky error flag that software must clear.

Each counted step can also feed a velocity pulse output, divided by 1, 4, 16 or 64. Software reaches the block through a small write/read register port with three addresses: a control byte, the position count and the maximum count.

Top module: `quad_pos_counter`

## Requirements
- R1: Mode codes (control bits [2:0]) 000, 011, 100 and 111 disable the decoder: encoder edges leave the position count unchanged.
- R2: Mode 001 (2x, index reset) and mode 010 (2x, maximum reset) change the count by one on each edge of phase A. Edges of phase B have no effect.
- R3: Mode 101 (4x, index reset) and mode 110 (4x, maximum reset) change the count by one on every single edge of phase A or of phase B.
- R4: When A leads B (phase state order 00, 10, 11, 01 as {A,B}), each step increments the count and control bit 7 reads 1. In the reverse order, each step decrements the count and bit 7 reads 0.
- R5: A sample in which A and B change together is ignored. The count and the direction bit stay unchanged.
- R6: In modes 001 and 101, a rising edge of the index input clears the position count to zero.
- R7: In modes 010 and 110, an up step from a count equal to the maximum-count register gives zero. A down step from zero gives the maximum count. The index input has no effect.
- R8: In modes 001 and 101, the count wraps modulo 2^16: an up step from 0xFFFF gives 0 and a down step from 0 gives 0xFFFF. Either wrap sets the error flag (control bit 6). In modes 010 and 110 the flag is never set.
- R9: Once set, the error flag stays set until a control write with bit 6 equal to 0.
- R10: When the decoder is on and control bit 5 is 0, the velocity pulse output is high for one cycle on every N-th counted step. N is 1, 4, 16 or 64 for control bits [4:3] = 00, 01, 10 or 11. When bit 5 is 1 or the decoder is off, the output stays low and the divider restarts.
- R11: After reset, the control byte, the position count and the maximum count all read 0, and the velocity pulse output is low.
- R12: Address 0 is the control byte (bits [15:8] read 0, bit 7 read-only), address 1 the position count and address 2 the maximum count. Writes to addresses 1 and 2 load the value, and each address reads back its current content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encA | input | 1 | Encoder phase A |
| encB | input | 1 | Encoder phase B |
| encIdx | input | 1 | Encoder index mark |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data, combinational |
| velPulse | output | 1 | Divided velocity pulse |

## Verification
The 16-bit wrap that sets the error flag is the hardest condition to reach from the pins alone, since it would take tens of thousands of encoder steps. The stimulus therefore loads the position register with 0xFFFF or 0 and then moves the encoder by one step in each direction. The 1:64 velocity ratio also needs a long run of steps, which a directed loop provides. Random walks in all four active modes, with random maximum counts, then check the position after every step against a model in the bench.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef struct packed {
    logic       step;     // one counted step this cycle
    logic       up;       // direction of that step
    logic       idxClr;   // index clear request
    logic       wrapMax;  // maximum-count reset mode
    logic       errEn;    // wrap error tracking enabled
    logic       velEn;    // velocity divider enabled
    logic [1:0] ratio;    // velocity divide select
  } qpc_strobe_t;
endpackage

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        encA,
  input  logic        encB,
  input  logic        encIdx,
  input  logic        cfgWr,
  input  logic [5:0]  cfgData,
  output qpc_strobe_t stb,
  output logic [7:0]  cfgByte
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] pinsIn;
  logic [2:0] syncQ [SYNC_STAGES];
  logic [2:0] prevQ;
  logic [2:0] curQ;
  logic [2:0] mode;
  logic [1:0] ratio;
  logic       velOff;
  logic       dirFwd;

  assign pinsIn = {encIdx, encB, encA};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinsIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign curQ = syncQ[LAST];

  logic aEdge, bEdge, idxRise, single, countEdge, stepUp;
  logic idxMode, maxMode, modeOn, x4;

  assign aEdge     = curQ[0] ^ prevQ[0];
  assign bEdge     = curQ[1] ^ prevQ[1];
  assign idxRise   = curQ[2] & ~prevQ[2];
  assign single    = aEdge ^ bEdge;
  assign x4        = mode[2];
  assign idxMode   = (mode[1:0] == 2'b01);
  assign maxMode   = (mode[1:0] == 2'b10);
  assign modeOn    = idxMode | maxMode;
  assign countEdge = single & (x4 | aEdge);
  assign stepUp    = aEdge ? (curQ[0] != curQ[1]) : (curQ[0] == curQ[1]);

  always_comb begin
    stb.step    = modeOn & countEdge;
    stb.up      = stepUp;
    stb.idxClr  = idxMode & idxRise;
    stb.wrapMax = maxMode;
    stb.errEn   = idxMode;
    stb.velEn   = modeOn & ~velOff;
    stb.ratio   = ratio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= '0;
      ratio  <= '0;
      velOff <= 1'b0;
      dirFwd <= 1'b0;
    end else begin
      if (cfgWr) begin
        mode   <= cfgData[2:0];
        ratio  <= cfgData[4:3];
        velOff <= cfgData[5];
      end
      if (stb.step) dirFwd <= stepUp;
    end
  end

  assign cfgByte = {dirFwd, 1'b0, velOff, ratio, mode};

  // R5: a sample with both phases changing never counts
  a_r5_no_double_step: assert property (@(posedge clk) disable iff (!rstN)
    (aEdge && bEdge) |-> !stb.step);
endmodule

// File: rtl/qpc_dp.sv
module qpc_dp
  import qpc_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpc_strobe_t      stb,
  input  logic             posWr,
  input  logic             maxWr,
  input  logic             errWr,
  input  logic             errWrVal,
  input  logic [POS_W-1:0] wrData,
  output logic [POS_W-1:0] posCnt,
  output logic [POS_W-1:0] maxCnt,
  output logic             errFlag,
  output logic             velPulse
);
  localparam int PRE_W = 6;
  localparam logic [POS_W-1:0] ALL_ONES = '1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic [POS_W-1:0] posNext;
  logic             errEvt;

  always_comb begin
    case (stb.ratio)
      2'd0:    preLast = PRE_W'(0);
      2'd1:    preLast = PRE_W'(3);
      2'd2:    preLast = PRE_W'(15);
      default: preLast = PRE_W'(63);
    endcase
  end

  always_comb begin
    posNext = posCnt;
    if (posWr)           posNext = wrData;
    else if (stb.idxClr) posNext = '0;
    else if (stb.step) begin
      if (stb.up) posNext = (stb.wrapMax && posCnt == maxCnt) ? '0 : posCnt + 1'b1;
      else        posNext = (stb.wrapMax && posCnt == '0) ? maxCnt : posCnt - 1'b1;
    end
  end

  assign errEvt = stb.step && stb.errEn && !stb.idxClr && !posWr &&
                  (stb.up ? (posCnt == ALL_ONES) : (posCnt == '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt   <= '0;
      maxCnt   <= '0;
      errFlag  <= 1'b0;
      preCnt   <= '0;
      velPulse <= 1'b0;
    end else begin
      posCnt <= posNext;
      if (maxWr) maxCnt <= wrData;
      if (errWr) errFlag <= errWrVal;
      else if (errEvt) errFlag <= 1'b1;
      if (!stb.velEn) begin
        preCnt   <= '0;
        velPulse <= 1'b0;
      end else if (stb.step) begin
        velPulse <= (preCnt == preLast);
        preCnt   <= (preCnt == preLast) ? '0 : preCnt + 1'b1;
      end else begin
        velPulse <= 1'b0;
      end
    end
  end

  // R6: index clear takes effect on the next cycle
  a_r6_index_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxClr && !posWr) |=> (posCnt == '0));
  // R7: up step at the maximum rolls to zero
  a_r7_roll_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && stb.up && stb.wrapMax && !posWr && posCnt == maxCnt) |=> (posCnt == '0));
  // R8: maximum-reset modes never raise the flag
  a_r8_no_err_in_max: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.errEn && !errFlag && !errWr) |=> !errFlag);
  // R9: the flag holds until written
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errWr) |=> errFlag);
  // R10: no pulse while the divider is disabled
  a_r10_vel_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !stb.velEn |=> !velPulse);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             encIdx,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [POS_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [POS_W-1:0] rdData,
  output logic             velPulse
);
  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_POS = 2'd1;
  localparam logic [1:0] ADDR_MAX = 2'd2;

  qpc_strobe_t      stb;
  logic [7:0]       cfgByte;
  logic [POS_W-1:0] posCnt, maxCnt;
  logic             errFlag;
  logic             cfgWr;

  assign cfgWr = wrEn && (wrAddr == ADDR_CFG);

  qpc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .cfgWr(cfgWr), .cfgData(wrData[5:0]), .stb(stb), .cfgByte(cfgByte)
  );

  qpc_dp #(.POS_W(POS_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .posWr(wrEn && (wrAddr == ADDR_POS)),
    .maxWr(wrEn && (wrAddr == ADDR_MAX)),
    .errWr(cfgWr), .errWrVal(wrData[6]), .wrData(wrData),
    .posCnt(posCnt), .maxCnt(maxCnt), .errFlag(errFlag), .velPulse(velPulse)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CFG: rdData = {{(POS_W-8){1'b0}}, cfgByte[7], errFlag, cfgByte[5:0]};
      ADDR_POS: rdData = posCnt;
      ADDR_MAX: rdData = maxCnt;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: tb/test_quad_pos_counter.sv
module test_quad_pos_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encA = 1'b0, encB = 1'b0, encIdx = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        velPulse;

  always #2 clk = ~clk;

  quad_pos_counter i_quad_pos_counter (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .velPulse(velPulse)
  );

  int nChecks = 0, nFail = 0, velSeen = 0;
  bit done = 0;

  // model state
  int          ph = 0;
  logic [15:0] ePos = 0, eMax = 0;
  bit          eErr = 0, eDir = 0, velOff = 0;
  logic [2:0]  mode = 0;
  logic [1:0]  ratio = 0;
  int          ePre = 0, eVel = 0;

  always @(negedge clk) if (rstN && velPulse) velSeen++;

  function automatic bit aOf(int p); return (p == 1 || p == 2); endfunction
  function automatic bit bOf(int p); return (p >= 2); endfunction
  function automatic bit isIdx(logic [2:0] m); return m[1:0] == 2'b01; endfunction
  function automatic bit isMax(logic [2:0] m); return m[1:0] == 2'b10; endfunction
  function automatic bit isOn(logic [2:0] m); return isIdx(m) || isMax(m); endfunction
  function automatic int ratioN(logic [1:0] r); return 1 << (2 * r); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rdAddr = a; #1; d = rdData;
  endtask

  task automatic setCfg(logic [2:0] m, logic [1:0] r, bit vo);
    mode = m; ratio = r; velOff = vo;
    wr(2'd0, {10'd0, vo, r, m} | (eErr ? 16'h40 : 16'h0));
    if (!(isOn(mode) && !velOff)) ePre = 0;
  endtask

  task automatic setPos(logic [15:0] v); wr(2'd1, v); ePos = v; endtask
  task automatic setMax(logic [15:0] v); wr(2'd2, v); eMax = v; endtask

  task automatic drive(int p, bit idx);
    @(negedge clk); encA = aOf(p); encB = bOf(p); encIdx = idx;
    repeat (5) @(negedge clk);
  endtask

  task automatic modelStep(bit up);
    if (isIdx(mode) && ((up && ePos == 16'hFFFF) || (!up && ePos == 0))) eErr = 1;
    if (up) ePos = (isMax(mode) && ePos == eMax) ? 16'h0 : ePos + 16'h1;
    else    ePos = (isMax(mode) && ePos == 0) ? eMax : ePos - 16'h1;
    eDir = up;
    if (!velOff) begin
      if (ePre == ratioN(ratio) - 1) begin ePre = 0; eVel++; end
      else ePre++;
    end
  endtask

  task automatic move(bit fwd);
    int np;
    np = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
    if (isOn(mode) && (mode[2] || aOf(np) != aOf(ph))) modelStep(fwd);
    ph = np;
    drive(ph, 0);
  endtask

  task automatic moveBoth();
    ph = (ph + 2) % 4;
    drive(ph, 0);
  endtask

  task automatic pulseIdx();
    drive(ph, 1);
    if (isIdx(mode)) ePos = 0;
    drive(ph, 0);
  endtask

  task automatic chkPos(string tag);
    logic [15:0] d;
    rd(2'd1, d); chk(tag, d, ePos);
  endtask

  task automatic chkCfg(string tag);
    logic [15:0] d;
    rd(2'd0, d); chk(tag, d, {8'd0, eDir, eErr, velOff, ratio, mode});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R11 reset state
    rd(2'd0, d); chk("R11 ctrl", d, 0);
    rd(2'd1, d); chk("R11 pos", d, 0);
    rd(2'd2, d); chk("R11 max", d, 0);
    chk("R11 vel", velPulse, 0);

    // R1 off codes
    foreach (d[i]) if (i < 1) ;
    setCfg(3'b000, 0, 1); for (int i = 0; i < 4; i++) move(1); chkPos("R1 mode000");
    setCfg(3'b100, 0, 1); for (int i = 0; i < 4; i++) move(1); chkPos("R1 mode100");
    setCfg(3'b111, 0, 1); for (int i = 0; i < 4; i++) move(0); chkPos("R1 mode111");
    setCfg(3'b011, 0, 1); for (int i = 0; i < 3; i++) move(1); chkPos("R1 mode011");

    // R2 2x counting
    setCfg(3'b001, 0, 1);
    for (int i = 0; i < 8; i++) move(1);
    chkPos("R2 2x fwd"); chk("R2 2x count", ePos, 4);
    for (int i = 0; i < 3; i++) move(0);
    chkPos("R2 2x rev");

    // R3/R4 4x counting and direction
    setCfg(3'b101, 0, 1); setPos(16'h0100);
    for (int i = 0; i < 8; i++) move(1);
    chkPos("R3 4x fwd"); chk("R3 4x count", ePos, 16'h0108);
    chkCfg("R4 dir fwd");
    for (int i = 0; i < 5; i++) move(0);
    chkPos("R4 4x rev"); chkCfg("R4 dir rev");

    // R5 simultaneous change ignored
    moveBoth(); chkPos("R5 both pos"); chkCfg("R5 both dir");
    move(1); move(1); moveBoth(); chkPos("R5 both pos2"); chkCfg("R5 both dir2");

    // R6 index clear
    pulseIdx(); chkPos("R6 idx clr"); chk("R6 zero", ePos, 0);
    setCfg(3'b001, 0, 1); setPos(16'h0033); pulseIdx(); chkPos("R6 idx clr 2x");

    // R7 max reset
    setCfg(3'b110, 0, 1); setMax(16'd5); setPos(16'd3);
    for (int i = 0; i < 3; i++) move(1);
    chkPos("R7 roll zero"); chk("R7 model", ePos, 0);
    move(0); chkPos("R7 under to max"); chk("R7 model max", ePos, 5);
    pulseIdx(); chkPos("R7 idx ignored");
    setPos(16'd0); move(0); chkPos("R8 max no wrap flag pos"); chkCfg("R8 max no flag");

    // R8/R9 wrap error
    setCfg(3'b101, 0, 1); setPos(16'hFFFF);
    move(1); chkPos("R8 over pos"); chkCfg("R8 over flag");
    for (int i = 0; i < 3; i++) move(1);
    chkCfg("R9 sticky");
    eErr = 0; setCfg(3'b101, 0, 1); chkCfg("R9 cleared");
    setPos(16'h0000); move(0); chkPos("R8 under pos"); chkCfg("R8 under flag");
    eErr = 0; setCfg(3'b010, 0, 1); setMax(16'd2);
    setPos(16'hFFFF); move(1); move(1); chkCfg("R8 no flag 2x max");

    // R12 register access
    setMax(16'hABCD); rd(2'd2, d); chk("R12 max rb", d, 16'hABCD);
    setPos(16'h1234); rd(2'd1, d); chk("R12 pos rb", d, 16'h1234);
    rd(2'd3, d); chk("R12 addr3", d, 0);

    // R10 velocity divider
    setMax(16'hFFFF);
    for (int r = 0; r < 4; r++) begin
      setCfg(3'b110, 2'(r), 1);
      setCfg(3'b110, 2'(r), 0);
      velSeen = 0; eVel = 0;
      for (int i = 0; i < 2 * ratioN(2'(r)) + 1; i++) move(1);
      @(negedge clk); #1;
      chk($sformatf("R10 ratio %0d", r), velSeen, eVel);
    end
    setCfg(3'b110, 0, 1); velSeen = 0; eVel = 0;
    for (int i = 0; i < 6; i++) move(0);
    @(negedge clk); #1; chk("R10 vel off", velSeen, 0);

    // random walks across active modes
    for (int blk = 0; blk < 8; blk++) begin
      logic [2:0] m;
      case ($urandom % 4)
        0: m = 3'b001; 1: m = 3'b010; 2: m = 3'b101; default: m = 3'b110;
      endcase
      eErr = 0;
      setCfg(m, 0, 1);
      setMax(16'($urandom % 12 + 1));
      setPos(16'($urandom % 12));
      if ($urandom % 2) setPos(16'hFFFE);
      for (int i = 0; i < 25; i++) begin
        int k;
        k = $urandom % 10;
        if (k == 0) moveBoth();
        else if (k == 1) pulseIdx();
        else move(k > 5);
        chkPos($sformatf("R%0s random mode %0b", isMax(m) ? "7" : "6", m));
      end
      chkCfg("R8 R9 random flag/dir");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule